// File: doc/BRIEF.md
# Status register and write permission unit

This unit sits beside the serial command decoder of a small nonvolatile memory. It owns the status byte (a write-enable latch, a two-bit block guard code, a lock-enable bit and a busy flag) and decides whether each write may go ahead. The decoder feeds it single-cycle strobes for the enable and disable commands. It also hands over a status byte or an array address once a write command has been fully shifted in. The chip select level and the active-low write-protect pin are sampled directly.

A write waits as pending until chip select returns high. On that edge the unit either commits it or rejects it. An accepted status write updates the guard and lock bits. An accepted array write raises a one-cycle go pulse toward the array sequencer. Either kind starts a busy interval of a fixed number of cycles. The guard and lock bits model nonvolatile cells: they have no reset and power up at parameter values. The two allow outputs give a registered verdict every cycle, so the decoder can refuse data early.

Top module: `wprot_status_unit`

## Requirements
- R1: status_o packs, from bit 7 down: lock-enable, three bits that read 0, guard[1:0] at bits 3:2, the write-enable latch at bit 1, and busy at bit 0.
- R2: After rst the latch, busy and any pending write are cleared. Guard and lock are not touched by rst and hold GUARD_INIT and LOCK_INIT from power-up until a status write changes them.
- R3: When not busy, wren_i sets the latch and wrdi_i clears it. If both strobes arrive together, the latch clears.
- R4: Guard code 00 protects nothing. Code 01 protects addresses whose top two bits are 11. Code 10 protects addresses whose top bit is 1. Code 11 protects every address.
- R5: arr_allow_o equals, one cycle later, latch AND NOT guarded(addr_i).
- R6: stat_allow_o equals, one cycle later, latch AND NOT (wp_n_i low AND lock-enable). A status write is committed only under that condition.
- R7: When chip select rises with a pending array write, latch set and address unguarded, arr_go_o pulses for one cycle and busy is 1 for WR_CYCLES cycles starting in that same cycle.
- R8: A committed status write takes lock-enable from data bit 7 and guard from data bits 3:2. Other data bits are ignored. Busy starts as in R7.
- R9: If wp_n_i falls while chip select is low and a status write is pending, that write is dropped. The later rise of chip select then neither commits nor rejects it.
- R10: Once a status write is committed, wp_n_i changes do not alter the stored bits or the busy interval.
- R11: The latch clears when a busy interval ends, and also when a pending write is rejected at the rise of chip select.
- R12: While busy, command strobes and loads are ignored, and guard and lock do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Chip select level, active low |
| wp_n_i | input | 1 | Write-protect pin, active low |
| wren_i | input | 1 | Enable-writes command strobe |
| wrdi_i | input | 1 | Disable-writes command strobe |
| stat_load_i | input | 1 | Status write byte received |
| stat_data_i | input | 8 | Status write byte |
| arr_load_i | input | 1 | Array write address received |
| addr_i | input | ADDR_W | Target array address |
| status_o | output | 8 | Status byte |
| arr_allow_o | output | 1 | Array write permitted for addr_i |
| stat_allow_o | output | 1 | Status write permitted |
| arr_go_o | output | 1 | Array write committed pulse |

## Verification
The bench builds the unit with ADDR_W=6, WR_CYCLES=3, GUARD_INIT=2'b10 and LOCK_INIT=0. The small address space puts the quarter and half guard boundaries at 48 and 32. The three-cycle busy interval lets strobes, pin toggles and loads be placed inside it. A non-zero guard power-up value shows that reset leaves the nonvolatile bits alone.

// File: rtl/wpu_pkg.sv
package wpu_pkg;
  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_STAT = 2'd1,
    PEND_ARR  = 2'd2
  } pend_e;

  localparam int STAT_W       = 8;
  localparam int BIT_BUSY     = 0;
  localparam int BIT_LATCH    = 1;
  localparam int BIT_GUARD_LO = 2;
  localparam int BIT_LOCK     = 7;
endpackage

// File: rtl/wpu_guard_decode.sv
module wpu_guard_decode (
  input  logic [1:0] guard_i,
  input  logic [1:0] top_i,
  output logic       hit_o
);
  always_comb begin
    unique case (guard_i)
      2'b00:   hit_o = 1'b0;
      2'b01:   hit_o = (top_i == 2'b11);
      2'b10:   hit_o = top_i[1];
      default: hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wpu_busy_timer.sv
module wpu_busy_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = busy_o && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      cnt_q  <= LOAD;
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wprot_status_unit.sv
module wprot_status_unit #(
  parameter int         ADDR_W     = 15,
  parameter int         WR_CYCLES  = 16,
  parameter logic [1:0] GUARD_INIT = 2'b00,
  parameter logic       LOCK_INIT  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_i,
  input  logic              wp_n_i,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              stat_load_i,
  input  logic [7:0]        stat_data_i,
  input  logic              arr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        status_o,
  output logic              arr_allow_o,
  output logic              stat_allow_o,
  output logic              arr_go_o
);
  import wpu_pkg::*;

  localparam int TOP = ADDR_W - 1;

  // Nonvolatile-style bits: no reset, power-up value from parameters.
  logic [1:0] guard_q = GUARD_INIT;
  logic       lock_q  = LOCK_INIT;

  logic       wel_q, cs_q, wp_q;
  pend_e      pend_q;
  logic [2:0] pend_data_q;   // {lock, guard[1:0]}
  logic [1:0] pend_top_q;
  logic       busy, done;
  logic       live_hit, pend_hit;
  logic       cs_rise, wp_fall, hw_lock, stat_ok, arr_ok;
  logic       go_stat, go_arr, reject;

  wire unused_data_bits = &{1'b0, stat_data_i[6:4], stat_data_i[1:0], addr_i[TOP-2:0]};

  wpu_guard_decode i_live_dec (.guard_i(guard_q), .top_i(addr_i[TOP -: 2]), .hit_o(live_hit));
  wpu_guard_decode i_pend_dec (.guard_i(guard_q), .top_i(pend_top_q),       .hit_o(pend_hit));

  wpu_busy_timer #(.CYCLES(WR_CYCLES)) i_timer (
    .clk(clk), .rst(rst), .start_i(go_stat | go_arr), .busy_o(busy), .done_o(done)
  );

  assign cs_rise = cs_n_i & ~cs_q;
  assign wp_fall = wp_q & ~wp_n_i;
  assign hw_lock = ~wp_n_i & lock_q;
  assign stat_ok = wel_q & ~hw_lock;
  assign arr_ok  = wel_q & ~pend_hit;
  assign go_stat = ~busy & cs_rise & (pend_q == PEND_STAT) & stat_ok;
  assign go_arr  = ~busy & cs_rise & (pend_q == PEND_ARR) & arr_ok;
  assign reject  = ~busy & cs_rise & (((pend_q == PEND_STAT) & ~stat_ok) |
                                      ((pend_q == PEND_ARR) & ~arr_ok));

  always_ff @(posedge clk) begin
    if (go_stat) begin
      lock_q  <= pend_data_q[2];
      guard_q <= pend_data_q[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q        <= 1'b0;
      cs_q         <= 1'b1;
      wp_q         <= 1'b1;
      pend_q       <= PEND_NONE;
      pend_data_q  <= '0;
      pend_top_q   <= '0;
      arr_allow_o  <= 1'b0;
      stat_allow_o <= 1'b0;
      arr_go_o     <= 1'b0;
    end else begin
      cs_q         <= cs_n_i;
      wp_q         <= wp_n_i;
      arr_allow_o  <= wel_q & ~live_hit;
      stat_allow_o <= stat_ok;
      arr_go_o     <= go_arr;

      if (done | reject)    wel_q <= 1'b0;
      else if (~busy & wrdi_i) wel_q <= 1'b0;
      else if (~busy & wren_i) wel_q <= 1'b1;

      if (cs_rise) begin
        pend_q <= PEND_NONE;
      end else if (~busy & ~cs_n_i) begin
        if (wp_fall && pend_q == PEND_STAT) begin
          pend_q <= PEND_NONE;
        end else if (stat_load_i) begin
          pend_q      <= PEND_STAT;
          pend_data_q <= {stat_data_i[BIT_LOCK], stat_data_i[BIT_GUARD_LO +: 2]};
        end else if (arr_load_i) begin
          pend_q     <= PEND_ARR;
          pend_top_q <= addr_i[TOP -: 2];
        end
      end
    end
  end

  always_comb begin
    status_o                       = '0;
    status_o[BIT_LOCK]             = lock_q;
    status_o[BIT_GUARD_LO +: 2]    = guard_q;
    status_o[BIT_LATCH]            = wel_q;
    status_o[BIT_BUSY]             = busy;
  end

  assert_go_needs_latch_R7: assert property (@(posedge clk) disable iff (rst)
    arr_go_o |-> busy && $past(wel_q) && !$past(pend_hit));

  assert_latch_off_after_busy_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !wel_q);

  assert_stat_locked_R6: assert property (@(posedge clk) disable iff (rst)
    stat_allow_o |-> $past(wp_n_i) || !$past(lock_q));

  assert_bits_hold_busy_R12: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(guard_q) && $stable(lock_q));

  assert_go_single_R7: assert property (@(posedge clk) disable iff (rst)
    arr_go_o |=> !arr_go_o);
endmodule

// File: tb/test_wprot_status_unit.sv
module test_wprot_status_unit;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 6;
  localparam int WRC = 3;
  localparam logic [1:0] GI = 2'b10;
  localparam logic       LI = 1'b0;

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, wp_n = 1'b1, wren = 1'b0, wrdi = 1'b0;
  logic stat_load = 1'b0, arr_load = 1'b0;
  logic [7:0] stat_data = '0;
  logic [AW-1:0] addr = '0;
  logic [7:0] status;
  logic arr_allow, stat_allow, arr_go;

  int tests = 0, fails = 0;
  bit finished = 0, cmp_en = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wprot_status_unit #(.ADDR_W(AW), .WR_CYCLES(WRC), .GUARD_INIT(GI), .LOCK_INIT(LI)) i_wprot_status_unit (
    .clk(clk), .rst(rst), .cs_n_i(cs_n), .wp_n_i(wp_n), .wren_i(wren), .wrdi_i(wrdi),
    .stat_load_i(stat_load), .stat_data_i(stat_data), .arr_load_i(arr_load), .addr_i(addr),
    .status_o(status), .arr_allow_o(arr_allow), .stat_allow_o(stat_allow), .arr_go_o(arr_go)
  );

  // Behavioural reference model
  int   m_bcnt = 0, m_pend = 0, m_paddr = 0;
  bit   m_wel = 0, m_lock = LI, m_csq = 1, m_wpq = 1, m_aa = 0, m_sa = 0, m_go = 0;
  bit [1:0] m_guard = GI;
  bit [7:0] m_pdata = 0;
  bit   s_busy, s_hw, s_rise, s_fall, s_commit, s_go, s_rej, s_done, s_nwel;

  function automatic bit guarded(bit [1:0] g, int a);
    int size = 1 << AW;
    case (g)
      2'b00: return 0;
      2'b01: return a >= (3 * size) / 4;
      2'b10: return a >= size / 2;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_wel = 0; m_bcnt = 0; m_pend = 0; m_csq = 1; m_wpq = 1;
      m_aa = 0; m_sa = 0; m_go = 0;
      cmp_en = 1;
    end else begin
      s_busy = m_bcnt > 0;
      s_hw   = !wp_n && m_lock;
      s_rise = cs_n && !m_csq;
      s_fall = m_wpq && !wp_n;
      s_done = s_busy && m_bcnt == 1;
      s_commit = 0; s_go = 0; s_rej = 0;
      m_aa = m_wel && !guarded(m_guard, int'(addr));
      m_sa = m_wel && !s_hw;
      s_nwel = m_wel;
      if (!s_busy) begin
        if (wrdi) s_nwel = 0;
        else if (wren) s_nwel = 1;
        if (s_rise && m_pend == 1) begin
          if (m_wel && !s_hw) s_commit = 1; else s_rej = 1;
        end else if (s_rise && m_pend == 2) begin
          if (m_wel && !guarded(m_guard, m_paddr)) s_go = 1; else s_rej = 1;
        end
      end
      if (s_commit) begin m_lock = m_pdata[7]; m_guard = m_pdata[3:2]; end
      if (s_done || s_rej) s_nwel = 0;
      if (s_rise) m_pend = 0;
      else if (!s_busy && !cs_n) begin
        if (s_fall && m_pend == 1) m_pend = 0;
        else if (stat_load) begin m_pend = 1; m_pdata = stat_data; end
        else if (arr_load) begin m_pend = 2; m_paddr = int'(addr); end
      end
      if (s_commit || s_go) m_bcnt = WRC;
      else if (s_busy) m_bcnt = m_bcnt - 1;
      m_go = s_go; m_wel = s_nwel; m_csq = cs_n; m_wpq = wp_n;
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !finished) begin
      automatic bit [7:0] exp_st = {m_lock, 3'b000, m_guard, m_wel, m_bcnt > 0};
      tests++;
      if (status !== exp_st) begin fails++; $display("FAIL R1 status act=%h exp=%h", status, exp_st); end
      tests++;
      if (arr_allow !== m_aa) begin fails++; $display("FAIL R5 arr_allow act=%0b exp=%0b", arr_allow, m_aa); end
      tests++;
      if (stat_allow !== m_sa) begin fails++; $display("FAIL R6 stat_allow act=%0b exp=%0b", stat_allow, m_sa); end
      tests++;
      if (arr_go !== m_go) begin fails++; $display("FAIL R7 arr_go act=%0b exp=%0b", arr_go, m_go); end
    end
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act !== exp) begin fails++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp); end
  endtask

  task automatic tick(); @(negedge clk); endtask
  task automatic pulse_wren(); wren = 1; tick(); wren = 0; endtask
  task automatic arr_write(int a);
    cs_n = 0; arr_load = 1; addr = AW'(a); tick(); arr_load = 0; tick(); cs_n = 1; tick();
  endtask
  task automatic stat_write(logic [7:0] d);
    cs_n = 0; stat_load = 1; stat_data = d; tick(); stat_load = 0; tick(); cs_n = 1; tick();
  endtask

  initial begin
    repeat (3) tick();
    rst = 0; tick();
    chk("R2 power-up status", status, {LI, 3'b000, GI, 2'b00});

    arr_write(5);
    chk("R7 no go without latch", arr_go, 0);
    chk("R11 latch still clear", status[1], 0);

    pulse_wren(); chk("R3 set latch", status[1], 1);
    wrdi = 1; tick(); wrdi = 0; chk("R3 clear latch", status[1], 0);
    pulse_wren();

    addr = 6'd47; tick(); chk("R4 half guard hides 47", arr_allow, 0);
    addr = 6'd31; tick(); chk("R5 unguarded 31 allowed", arr_allow, 1);

    arr_write(5);
    chk("R7 go pulse", arr_go, 1);
    chk("R7 busy starts", status[0], 1);
    wrdi = 1; tick(); wrdi = 0;
    chk("R12 strobe ignored while busy", status[1], 1);
    repeat (WRC - 1) tick();
    chk("R11 latch and busy clear at end", status[1:0], 0);

    pulse_wren(); arr_write(40);
    chk("R4 guarded write refused", arr_go, 0);
    chk("R11 latch cleared by refusal", status[1], 0);

    pulse_wren(); stat_write(8'hF7);
    chk("R8 status committed", status, 8'h87);
    repeat (WRC) tick();
    chk("R1 status after write", status, 8'h84);

    pulse_wren();
    addr = 6'd47; tick(); chk("R4 quarter leaves 47", arr_allow, 1);
    addr = 6'd48; tick(); chk("R4 quarter guards 48", arr_allow, 0);
    wp_n = 0; tick(); chk("R6 locked by pin", stat_allow, 0);
    wp_n = 1; tick(); chk("R6 open with pin high", stat_allow, 1);

    wp_n = 0; tick();
    stat_write(8'h0C);
    chk("R6 locked write refused", status, 8'h84);

    wp_n = 1; tick(); pulse_wren();
    cs_n = 0; stat_load = 1; stat_data = 8'h0C; tick(); stat_load = 0;
    wp_n = 0; tick(); wp_n = 1; tick(); cs_n = 1; tick();
    chk("R9 aborted write leaves bits", status, 8'h86);

    stat_write(8'h0C);
    chk("R8 unlock commit", status, 8'h0F);
    wp_n = 0; tick();
    chk("R10 pin after commit", status, 8'h0F);
    wp_n = 1; repeat (WRC - 1) tick();
    chk("R10 bits kept", status, 8'h0C);

    pulse_wren();
    addr = 6'd0; tick(); chk("R4 full guard", arr_allow, 0);
    wren = 1; wrdi = 1; tick(); wren = 0; wrdi = 0;
    chk("R3 both strobes clear", status[1], 0);

    pulse_wren(); stat_write(8'h00); repeat (WRC) tick();
    pulse_wren();
    addr = 6'd63; tick(); chk("R4 no guard", arr_allow, 1);

    repeat (2) tick();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule